// File: doc/BRIEF.md
# Framebuffer Control and Palette Register Block

This block is the write-side register file of a palette-based framebuffer controller. It sits on a simple memory-mapped bus and decodes a 64 KiB control window. Inside that window it keeps a 256-entry colour lookup table of red, green and blue bytes, plus the display width and height registers. The scan-out logic reads the colour table through a combinational lookup port and reads the screen dimensions directly.

Each entry of the colour table takes eight bytes of address space, and only the first three of them hold data. The dimension registers are built up from byte writes that land at unusual bit offsets. Halfword and word accesses are split into byte accesses. Any write into the window, whether it hits a register or not, produces a one-cycle refresh request so that scan-out redraws the whole screen. Reads from the window always return zero.

Top module: `fbctl_regs`

## Requirements
- R1: Only bus address bits 15:0 are decoded. Higher address bits have no effect on which register an access reaches.
- R2: A byte written at a window offset below 0x0800 goes to colour entry offset[10:3]. Component offset[2:0] selects the colour: 0 is red, 1 is green and 2 is blue. The lookup port returns {red, green, blue} in bits 23:16, 15:8 and 7:0 for the entry on `pal_rd_idx`.
- R3: Bytes written to colour component offsets 3 to 7 change no stored value.
- R4: A byte written at offset 0x0918 replaces width bits 9:2. A byte written at offset 0x0919 replaces width bits 17:10. Width bits 1:0 and all other width bits are kept.
- R5: A byte written at offset 0x0940 replaces height bits 6:0 with byte bits 7:1. A byte written at offset 0x0941 replaces height bits 14:7.
- R6: `bus_size` 0 selects a byte access, 1 a halfword access, and 2 or 3 a word access. Byte k of an access takes data bits 8k+7:8k and goes to window offset (offset + k) mod 65536, so the bytes are laid out little-endian and wrap within the window.
- R7: A read (`bus_valid` high, `bus_write` low) returns zero on `bus_rdata`, changes no stored value and raises no refresh request.
- R8: `refresh_req` is high for exactly the cycle after each write cycle, including writes to undecoded offsets, and is low after every other cycle.
- R9: Writes to offsets of 0x0800 and above, other than the four dimension bytes, change no stored value.
- R10: A synchronous active-low reset clears every colour entry and sets width and height to zero.
- R11: A write is visible on `disp_width`, `disp_height` and `pal_rd_rgb` in the cycle after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| bus_addr | input | ADDR_W | Byte address; only bits 15:0 are decoded |
| bus_wdata | input | DATA_W | Write data; byte k is in bits 8k+7:8k |
| bus_rdata | output | DATA_W | Read data, always zero |
| refresh_req | output | 1 | One-cycle full-refresh request |
| pal_rd_idx | input | IDX_W | Colour entry index for scan-out |
| pal_rd_rgb | output | 24 | {red, green, blue} of the selected entry |
| disp_width | output | 18 | Display width in pixels |
| disp_height | output | 15 | Display height in lines |

## Verification
Every stored result and the refresh pulse appear one clock edge after the write is accepted. The bench drives each access on a falling edge and holds it across one rising edge. It samples the dimensions, the lookup port and `refresh_req` at the next falling edge, and checks that `refresh_req` has dropped one falling edge later. `bus_rdata` is combinational, so it is sampled inside the read cycle, before the accepting edge. The lookup port is combinational too: the bench changes the index and waits a short delay before it compares the result.

// File: rtl/fbctl_pkg.sv
// Package: fbctl_pkg
// Shared constants and types for the framebuffer control register block.
// Assumes a 16-bit decoded window and byte-granular register updates.
package fbctl_pkg;
    localparam int WIN_W       = 16;
    localparam int DISP_W_BITS = 18;
    localparam int DISP_H_BITS = 15;

    localparam logic [WIN_W-1:0] WID_LO_OFS = 16'h0918;
    localparam logic [WIN_W-1:0] WID_HI_OFS = 16'h0919;
    localparam logic [WIN_W-1:0] HGT_LO_OFS = 16'h0940;
    localparam logic [WIN_W-1:0] HGT_HI_OFS = 16'h0941;

    // Access size codes
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    // One byte-sized write produced by splitting a bus access
    typedef struct packed {
        logic             en;
        logic [WIN_W-1:0] ofs;
        logic [7:0]       data;
    } byte_wr_t;
endpackage

// File: rtl/fbctl_lane_split.sv
// Module: fbctl_lane_split
// Splits one bus write into per-byte writes in little-endian order.
// Byte k goes to window offset (offset + k), wrapping in the window.
// Assumes DATA_W is a multiple of 8. Reads produce no byte writes.
module fbctl_lane_split
    import fbctl_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8
) (
    input  logic                   bus_valid,
    input  logic                   bus_write,
    input  logic [1:0]             bus_size,
    input  logic [WIN_W-1:0]       win_ofs,
    input  logic [DATA_W-1:0]      bus_wdata,
    output byte_wr_t [LANES-1:0]   lanes
);
    int nbytes;

    // Number of bytes that the access size covers
    always_comb begin
        case (bus_size)
            SZ_BYTE: nbytes = 1;
            SZ_HALF: nbytes = 2;
            default: nbytes = 4;
        endcase
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // One byte write per lane, enabled when the access size covers the lane
        always_comb begin
            lanes[k].en   = bus_valid && bus_write && (k < nbytes);
            lanes[k].ofs  = win_ofs + WIN_W'(k);
            lanes[k].data = bus_wdata[8*k +: 8];
        end
    end
endmodule

// File: rtl/fbctl_palette.sv
// Module: fbctl_palette
// Colour lookup table. Each entry spans 8 bytes of offset space and
// holds three live bytes: red, green, blue. Bytes 3..7 are dropped.
// Assumes PAL_ENTRIES*8 fits in the window.
module fbctl_palette
    import fbctl_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int PAL_ENTRIES = 256,
    localparam int IDX_W      = $clog2(PAL_ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  byte_wr_t [LANES-1:0] lanes,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [23:0]          rd_rgb
);
    localparam logic [WIN_W-1:0] PAL_LIMIT = WIN_W'(PAL_ENTRIES * 8);

    logic [2:0][7:0] entry [PAL_ENTRIES];

    // Store each live colour byte; clear the whole table on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < PAL_ENTRIES; e++) begin
                entry[e] <= '0;
            end
        end else begin
            for (int k = 0; k < LANES; k++) begin
                if (lanes[k].en && (lanes[k].ofs < PAL_LIMIT) &&
                    (lanes[k].ofs[2:0] < 3'd3)) begin
                    entry[lanes[k].ofs[IDX_W+2:3]][lanes[k].ofs[1:0]] <= lanes[k].data;
                end
            end
        end
    end

    // Lookup port for scan-out: {red, green, blue}
    assign rd_rgb = {entry[rd_idx][0], entry[rd_idx][1], entry[rd_idx][2]};
endmodule

// File: rtl/fbctl_dims.sv
// Module: fbctl_dims
// Display width and height registers, assembled from byte writes at
// shifted bit positions. Bits that no byte reaches stay at zero.
module fbctl_dims
    import fbctl_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  byte_wr_t [LANES-1:0]   lanes,
    output logic [DISP_W_BITS-1:0] width,
    output logic [DISP_H_BITS-1:0] height
);
    // Merge each dimension byte into its bit field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width  <= '0;
            height <= '0;
        end else begin
            for (int k = 0; k < LANES; k++) begin
                if (lanes[k].en) begin
                    case (lanes[k].ofs)
                        WID_LO_OFS: width[9:2]   <= lanes[k].data;
                        WID_HI_OFS: width[17:10] <= lanes[k].data;
                        HGT_LO_OFS: height[6:0]  <= lanes[k].data[7:1];
                        HGT_HI_OFS: height[14:7] <= lanes[k].data;
                        default: ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/fbctl_regs.sv
// Module: fbctl_regs (top)
// Control window of a palette framebuffer: colour table, display size,
// and a one-cycle refresh request after each write. Reads return zero.
// Assumes one access per cycle with no wait states.
module fbctl_regs
    import fbctl_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int PAL_ENTRIES = 256,
    localparam int IDX_W      = $clog2(PAL_ENTRIES),
    localparam int LANES      = DATA_W / 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_valid,
    input  logic                   bus_write,
    input  logic [1:0]             bus_size,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    output logic                   refresh_req,
    input  logic [IDX_W-1:0]       pal_rd_idx,
    output logic [23:0]            pal_rd_rgb,
    output logic [DISP_W_BITS-1:0] disp_width,
    output logic [DISP_H_BITS-1:0] disp_height
);
    byte_wr_t [LANES-1:0] lanes;

    fbctl_lane_split #(.DATA_W(DATA_W)) u_split (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_size  (bus_size),
        .win_ofs   (bus_addr[WIN_W-1:0]),
        .bus_wdata (bus_wdata),
        .lanes     (lanes)
    );

    fbctl_palette #(.LANES(LANES), .PAL_ENTRIES(PAL_ENTRIES)) u_pal (
        .clk    (clk),
        .rst_n  (rst_n),
        .lanes  (lanes),
        .rd_idx (pal_rd_idx),
        .rd_rgb (pal_rd_rgb)
    );

    fbctl_dims #(.LANES(LANES)) u_dims (
        .clk    (clk),
        .rst_n  (rst_n),
        .lanes  (lanes),
        .width  (disp_width),
        .height (disp_height)
    );

    // Pulse the refresh request once per accepted write
    always_ff @(posedge clk) begin
        if (!rst_n) refresh_req <= 1'b0;
        else        refresh_req <= bus_valid && bus_write;
    end

    // The window has no readable state
    assign bus_rdata = '0;
endmodule

// File: rtl/fbctl_regs_chk.sv
// Module: fbctl_regs_chk
// Protocol and update checks for fbctl_regs, attached with bind.
module fbctl_regs_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [1:0]        bus_size,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              refresh_req,
    input logic [IDX_W-1:0]  pal_rd_idx,
    input logic [23:0]       pal_rd_rgb,
    input logic [17:0]       disp_width,
    input logic [14:0]       disp_height
);
    logic wr_now;
    assign wr_now = bus_valid && bus_write;

    p_refresh_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_now |=> refresh_req);

    p_refresh_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_now |=> !refresh_req);

    p_read_no_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> ($stable(disp_width) && $stable(disp_height)));

    p_width_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_now && bus_size == 2'd0 && bus_addr[15:0] == 16'h0918) |=>
        (disp_width[9:2] == $past(bus_wdata[7:0]) &&
         disp_width[17:10] == $past(disp_width[17:10]) &&
         disp_width[1:0] == $past(disp_width[1:0])));

    p_height_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_now && bus_size == 2'd0 && bus_addr[15:0] == 16'h0940) |=>
        (disp_height[6:0] == $past(bus_wdata[7:1]) &&
         disp_height[14:7] == $past(disp_height[14:7])));

    p_undecoded_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_now && bus_addr[15:0] >= 16'h0A00 && bus_addr[15:0] <= 16'hFFF0) |=>
        ($stable(disp_width) && $stable(disp_height)));

    p_red_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_now && bus_size == 2'd0 && bus_addr[15:0] < 16'h0800 &&
         bus_addr[2:0] == 3'd0 && pal_rd_idx == bus_addr[10:3]) |=>
        ((pal_rd_idx != $past(pal_rd_idx)) ||
         (pal_rd_rgb[23:16] == $past(bus_wdata[7:0]))));

    p_pad_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_now && bus_size == 2'd0 && bus_addr[15:0] < 16'h0800 &&
         bus_addr[2:0] >= 3'd3) |=>
        ((pal_rd_idx != $past(pal_rd_idx)) || $stable(pal_rd_rgb)));
endmodule

bind fbctl_regs fbctl_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_size    (bus_size),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .refresh_req (refresh_req),
    .pal_rd_idx  (pal_rd_idx),
    .pal_rd_rgb  (pal_rd_rgb),
    .disp_width  (disp_width),
    .disp_height (disp_height)
);

// File: tb/fbctl_regs_test.sv
`timescale 1ns/1ps
module fbctl_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_size = 2'd0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        refresh_req;
    logic [7:0]  pal_rd_idx = '0;
    logic [23:0] pal_rd_rgb;
    logic [17:0] disp_width;
    logic [14:0] disp_height;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fbctl_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .refresh_req(refresh_req), .pal_rd_idx(pal_rd_idx),
        .pal_rd_rgb(pal_rd_rgb), .disp_width(disp_width), .disp_height(disp_height)
    );

    typedef struct packed {
        logic [1:0]  sz;
        logic [31:0] addr;
        logic [31:0] data;
        logic [17:0] ew;
        logic [14:0] eh;
    } vec_t;

    // Writes applied in order; ew/eh are the expected dimensions afterwards
    localparam vec_t VECS [12] = '{
        '{2'd0, 32'h0000_0918, 32'h0000_00AB, 18'h002AC, 15'h0000}, // R4 low byte
        '{2'd0, 32'h0000_0919, 32'h0000_003C, 18'h0F2AC, 15'h0000}, // R4 high byte
        '{2'd0, 32'h0000_0940, 32'h0000_00FF, 18'h0F2AC, 15'h007F}, // R5 low byte
        '{2'd0, 32'h0000_0941, 32'h0000_0012, 18'h0F2AC, 15'h097F}, // R5 high byte
        '{2'd1, 32'h0000_0918, 32'h0000_0102, 18'h00408, 15'h097F}, // R6 halfword
        '{2'd2, 32'h0000_0940, 32'hDEAD_0281, 18'h00408, 15'h0140}, // R6 word
        '{2'd2, 32'h0000_0920, 32'hFFFF_FFFF, 18'h00408, 15'h0140}, // R9 undecoded
        '{2'd0, 32'h1234_0918, 32'h0000_00FF, 18'h007FC, 15'h0140}, // R1 high addr bits
        '{2'd2, 32'h0000_0916, 32'h4433_2211, 18'h110CC, 15'h0140}, // R6 straddle
        '{2'd1, 32'hABCD_FFFF, 32'h0000_5566, 18'h110CC, 15'h0140}, // R6 wrap
        '{2'd0, 32'h0000_0941, 32'h0000_00FF, 18'h110CC, 15'h7FC0}, // R5 max byte
        '{2'd0, 32'h0000_0800, 32'h0000_0099, 18'h110CC, 15'h7FC0}  // R9 first undecoded
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive one write across one rising edge; returns at the following falling edge
    task automatic wr(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_size = sz; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic pal(input logic [7:0] idx, input logic [23:0] exp, input string req);
        pal_rd_idx = idx;
        #0.5;
        chk(req, {8'h00, pal_rd_rgb}, {8'h00, exp});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R10: reset state
        chk("R10 width", {14'd0, disp_width}, 32'd0);
        chk("R10 height", {17'd0, disp_height}, 32'd0);
        chk("R8 idle after reset", {31'd0, refresh_req}, 32'd0);
        pal(8'd0, 24'h000000, "R10 entry 0");

        // Vector table: R1 R4 R5 R6 R8 R9 R11
        for (int i = 0; i < 12; i++) begin
            wr(VECS[i].sz, VECS[i].addr, VECS[i].data);
            chk($sformatf("R11 vec %0d width", i), {14'd0, disp_width}, {14'd0, VECS[i].ew});
            chk($sformatf("R11 vec %0d height", i), {17'd0, disp_height}, {17'd0, VECS[i].eh});
            chk($sformatf("R8 vec %0d pulse", i), {31'd0, refresh_req}, 32'd1);
            @(negedge clk);
            chk($sformatf("R8 vec %0d drop", i), {31'd0, refresh_req}, 32'd0);
        end
        // R6: the wrapped byte of the halfword at 0xFFFF landed on entry 0 red
        pal(8'd0, 24'h550000, "R6 wrap to entry 0");

        // R2: word fills red, green, blue of entry 1
        wr(2'd2, 32'h0000_0008, 32'h0033_2211);
        pal(8'd1, 24'h112233, "R2 entry 1 rgb");
        // R3: offsets 4..7 of entry 1 ignored, entry 2 untouched
        wr(2'd2, 32'h0000_000C, 32'hFFFF_FFFF);
        pal(8'd1, 24'h112233, "R3 pad bytes entry 1");
        pal(8'd2, 24'h000000, "R3 entry 2 untouched");
        // R3: byte at component offset 3
        wr(2'd0, 32'h0000_0013, 32'h0000_00EE);
        pal(8'd2, 24'h000000, "R3 offset 3");
        // R2: last entry, blue component
        wr(2'd0, 32'h0000_07FA, 32'h0000_0077);
        pal(8'd255, 24'h000077, "R2 entry 255 blue");
        // R2: green via halfword at offset 1
        wr(2'd1, 32'h0000_0011, 32'h0000_A5C3);
        pal(8'd2, 24'h00C3A5, "R2 entry 2 green blue");

        // R7: read returns zero, no refresh, no change
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_size = 2'd2; bus_addr = 32'h0000_0918;
        bus_wdata = 32'h1234_5678;
        #0.5;
        chk("R7 rdata zero", bus_rdata, 32'd0);
        @(negedge clk);
        bus_valid = 1'b0;
        chk("R7 no refresh", {31'd0, refresh_req}, 32'd0);
        chk("R7 width kept", {14'd0, disp_width}, 32'h110CC);
        pal(8'd1, 24'h112233, "R7 entry 1 kept");

        // R8: back-to-back writes keep the pulse high each following cycle
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_size = 2'd0; bus_addr = 32'h0000_4000;
        @(negedge clk);
        chk("R8 back-to-back first", {31'd0, refresh_req}, 32'd1);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        chk("R8 back-to-back second", {31'd0, refresh_req}, 32'd1);
        @(negedge clk);
        chk("R8 back-to-back drop", {31'd0, refresh_req}, 32'd0);

        // R10: reset after activity
        do_reset();
        chk("R10 width cleared", {14'd0, disp_width}, 32'd0);
        chk("R10 height cleared", {17'd0, disp_height}, 32'd0);
        pal(8'd1, 24'h000000, "R10 entry 1 cleared");
        pal(8'd255, 24'h000000, "R10 entry 255 cleared");

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule